// File: doc/BRIEF.md
# Vector Lane Predicate Mask Generator

This block decides, for a 128-bit vector datapath, which of the sixteen byte lanes an instruction may write. It combines three restrictions into one active-high byte mask. The first is a per-lane predicate with two then/else step fields. The second is a tail clip on the last pass of a counted loop. The third removes beats that were already completed before an instruction was interrupted and resumed. Elements wider than a byte read the mask at their lowest byte: 16-bit elements use the even bits, and 32-bit elements use bits 0, 4, 8 and 12.

The block holds the predicate state and the resume code. The mask is combinational from the held state and the present loop inputs. A load strobe writes both state values. An advance strobe, given once an instruction completes, steps the resume state machine. It also steps the predicate through its then/else sequence.

The resume code is a small state machine whose states are NONE (0), BEAT0 (1), BEAT01 (2), BEAT012 (4) and BEAT012_NEXT0 (5). On advance it takes one of two transitions: RESUME_REARM goes from BEAT012_NEXT0 to BEAT0, and RESUME_CLEAR goes from any other code to NONE. Both transitions need the condition field to be zero. If the condition field is nonzero, the HOLD transition keeps the code. A load strobe takes the LOAD transition, which overrides all the others.

Top module: `vlane_pred_mask`

## Requirements
- R1: A synchronous reset sets the held predicate to all zeros and the resume code to NONE (0). With no tail clip and a zero condition field, the mask then reads 0xFFFF.
- R2: The predicate word has these fields: lane bits in [15:0], the low step field in [19:16] and the high step field in [23:20]. The mask starts from the lane bits. Bits 7:0 are forced to 1 when the low step field is zero, and bits 15:8 are forced to 1 when the high step field is zero.
- R3: A tail clip applies when the size code is below 4 and the loop count is at most 16 >> size. Size codes 0, 1, 2 and 3 mean 8-, 16-, 32- and 64-bit elements. When the clip applies, only the lowest (count << size) mask bits are kept, and a count of 0 clears the whole mask.
- R4: With a zero condition field, the resume code gates the mask. NONE (0) keeps it, BEAT0 (1) ANDs it with 0xFFF0, BEAT01 (2) with 0xFF00, and BEAT012 (4) or BEAT012_NEXT0 (5) with 0xF000.
- R5: Any other resume code raises bad_resume_o when the condition field is zero, and the beat stage then leaves the mask unchanged.
- R6: A nonzero condition field disables beat gating and bad_resume_o. It also keeps the resume code unchanged on advance.
- R7: On advance with a zero condition field, the resume code becomes BEAT0 if it was BEAT012_NEXT0, and NONE otherwise.
- R8: On advance, the predicate does not change if both step fields are zero.
- R9: On advance, when either step field is nonzero, a step field greater than 8 inverts its own byte of the lane bits: the low field acts on bits 7:0 and the high field on bits 15:8. Each step field is then shifted left by one and truncated to 4 bits.
- R10: Load writes the predicate and the resume code in the next cycle and takes priority over a simultaneous advance.
- R11: With neither load nor advance, the predicate and the resume code hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Write load_pred_i and load_resume_i into the state |
| load_pred_i | input | 24 | Predicate value to load (field layout as in R2) |
| load_resume_i | input | 4 | Resume code to load |
| advance_i | input | 1 | Instruction completed; step the resume and predicate state |
| cond_lo_i | input | 4 | Low condition field; zero enables resume handling |
| elem_sz_i | input | SZ_W | Element size code for the tail clip; 4 or more disables it |
| loop_cnt_i | input | CNT_W | Remaining loop element count |
| lane_mask_o | output | 16 | Active byte lanes |
| pred_o | output | 24 | Held predicate |
| resume_o | output | 4 | Held resume code |
| bad_resume_o | output | 1 | Unsupported resume code while the condition field is zero |

## Verification
Wrong held state shows on lane_mask_o in the same cycle, with no further registers on the path. A bad step of the predicate fields or lane bits shows on pred_o, and on the mask, one cycle after the advance. A wrong resume transition shows as a wrongly gated low beat on the next instruction. It shows at once on resume_o. Because every stage can only clear bits, a fault that sets an extra bit can only come from the base stage. A missing clear points at the tail stage or the beat stage.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
    localparam int LANES  = 16;
    localparam int HALF   = LANES / 2;
    localparam int BEAT_B = LANES / 4;
    localparam int FLD_W  = 4;
    localparam int RES_W  = 4;
    localparam int PRED_W = LANES + 2 * FLD_W;

    typedef enum logic [RES_W-1:0] {
        RS_NONE         = 4'd0,
        RS_BEAT0        = 4'd1,
        RS_BEAT01       = 4'd2,
        RS_BEAT012      = 4'd4,
        RS_BEAT012_NEXT = 4'd5
    } resume_e;

    typedef struct packed {
        logic [FLD_W-1:0] fld_hi;
        logic [FLD_W-1:0] fld_lo;
        logic [LANES-1:0] lanes;
    } pred_t;
endpackage

// File: rtl/vlp_base_mask.sv
module vlp_base_mask
    import vlp_pkg::*;
(
    input  pred_t            pred_i,
    output logic [LANES-1:0] base_o
);
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [FLD_W-1:0] fld;
        if (h == 0) begin : g_lo
            assign fld = pred_i.fld_lo;
        end else begin : g_hi
            assign fld = pred_i.fld_hi;
        end
        // a zero step field means no predication on this half
        assign base_o[h*HALF +: HALF] = (fld == '0) ? {HALF{1'b1}}
                                                    : pred_i.lanes[h*HALF +: HALF];
    end
endmodule

// File: rtl/vlp_tail_clip.sv
module vlp_tail_clip
    import vlp_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SZ_W  = 3
) (
    input  logic [LANES-1:0] mask_i,
    input  logic [SZ_W-1:0]  sz_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [LANES-1:0] mask_o
);
    localparam int LOG_L = $clog2(LANES);

    logic             active;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] keep_len;
    logic [LANES-1:0] keep;

    always_comb begin
        limit    = CNT_W'(LANES) >> sz_i;
        active   = (sz_i < SZ_W'(LOG_L)) && (cnt_i <= limit);
        keep_len = cnt_i << sz_i;
        for (int i = 0; i < LANES; i++) begin
            keep[i] = !active || (CNT_W'(i) < keep_len);
        end
        mask_o = mask_i & keep;
    end
endmodule

// File: rtl/vlp_beat_gate.sv
module vlp_beat_gate
    import vlp_pkg::*;
(
    input  logic [LANES-1:0] mask_i,
    input  logic [FLD_W-1:0] cond_lo_i,
    input  logic [RES_W-1:0] resume_i,
    output logic [LANES-1:0] mask_o,
    output logic             bad_o
);
    localparam logic [LANES-1:0] ALL   = {LANES{1'b1}};
    localparam logic [LANES-1:0] KEEP1 = ALL << (BEAT_B * 1);
    localparam logic [LANES-1:0] KEEP2 = ALL << (BEAT_B * 2);
    localparam logic [LANES-1:0] KEEP3 = ALL << (BEAT_B * 3);

    logic [LANES-1:0] keep;

    always_comb begin
        keep  = ALL;
        bad_o = 1'b0;
        if (cond_lo_i == '0) begin
            case (resume_i)
                RS_NONE:                     keep = ALL;
                RS_BEAT0:                    keep = KEEP1;
                RS_BEAT01:                   keep = KEEP2;
                RS_BEAT012, RS_BEAT012_NEXT: keep = KEEP3;
                default:                     bad_o = 1'b1;
            endcase
        end
        mask_o = mask_i & keep;
    end
endmodule

// File: rtl/vlp_pred_step.sv
module vlp_pred_step
    import vlp_pkg::*;
(
    input  pred_t cur_i,
    output pred_t nxt_i
);
    localparam logic [FLD_W-1:0] FLIP_MIN = FLD_W'(8);

    always_comb begin
        nxt_i = cur_i;
        if (cur_i.fld_lo != '0 || cur_i.fld_hi != '0) begin
            if (cur_i.fld_lo > FLIP_MIN) begin
                nxt_i.lanes[HALF-1:0] = ~cur_i.lanes[HALF-1:0];
            end
            if (cur_i.fld_hi > FLIP_MIN) begin
                nxt_i.lanes[LANES-1:HALF] = ~cur_i.lanes[LANES-1:HALF];
            end
            nxt_i.fld_lo = {cur_i.fld_lo[FLD_W-2:0], 1'b0};
            nxt_i.fld_hi = {cur_i.fld_hi[FLD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/vlane_pred_mask.sv
module vlane_pred_mask
    import vlp_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SZ_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [PRED_W-1:0] load_pred_i,
    input  logic [RES_W-1:0]  load_resume_i,
    input  logic              advance_i,
    input  logic [FLD_W-1:0]  cond_lo_i,
    input  logic [SZ_W-1:0]   elem_sz_i,
    input  logic [CNT_W-1:0]  loop_cnt_i,
    output logic [LANES-1:0]  lane_mask_o,
    output logic [PRED_W-1:0] pred_o,
    output logic [RES_W-1:0]  resume_o,
    output logic              bad_resume_o
);
    pred_t            pred_q, pred_nx, pred_stepped;
    logic [RES_W-1:0] resume_q, resume_nx;
    logic [LANES-1:0] base_mask, tail_mask;

    vlp_base_mask u_base (
        .pred_i (pred_q),
        .base_o (base_mask)
    );

    vlp_tail_clip #(.CNT_W(CNT_W), .SZ_W(SZ_W)) u_tail (
        .mask_i (base_mask),
        .sz_i   (elem_sz_i),
        .cnt_i  (loop_cnt_i),
        .mask_o (tail_mask)
    );

    vlp_beat_gate u_beat (
        .mask_i    (tail_mask),
        .cond_lo_i (cond_lo_i),
        .resume_i  (resume_q),
        .mask_o    (lane_mask_o),
        .bad_o     (bad_resume_o)
    );

    vlp_pred_step u_step (
        .cur_i (pred_q),
        .nxt_i (pred_stepped)
    );

    // next state: LOAD over advance; advance takes REARM / CLEAR / HOLD
    always_comb begin
        pred_nx   = pred_q;
        resume_nx = resume_q;
        if (load_i) begin
            pred_nx   = pred_t'(load_pred_i);
            resume_nx = load_resume_i;
        end else if (advance_i) begin
            pred_nx = pred_stepped;
            if (cond_lo_i == '0) begin
                if (resume_q == RS_BEAT012_NEXT) begin
                    resume_nx = RS_BEAT0;
                end else begin
                    resume_nx = RS_NONE;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pred_q   <= '0;
            resume_q <= RS_NONE;
        end else begin
            pred_q   <= pred_nx;
            resume_q <= resume_nx;
        end
    end

    // outputs
    always_comb begin
        pred_o   = pred_q;
        resume_o = resume_q;
    end

    p_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !advance_i) |=> ($stable(pred_q) && $stable(resume_q)));

    p_resume_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && advance_i && cond_lo_i != '0) |=> $stable(resume_q));

    p_resume_step_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && advance_i && cond_lo_i == '0)
            |=> (resume_q == RS_NONE || resume_q == RS_BEAT0));

    p_pred_idle_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && advance_i && pred_q.fld_lo == '0 && pred_q.fld_hi == '0)
            |=> $stable(pred_q));

    p_field_shift_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && advance_i) |=> (!pred_q.fld_lo[0] && !pred_q.fld_hi[0]));

    p_load_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (pred_o == $past(load_pred_i) && resume_o == $past(load_resume_i)));

    p_bad_passes_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        bad_resume_o |-> (lane_mask_o == tail_mask));

    p_cond_blocks_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (cond_lo_i != '0) |-> (lane_mask_o == tail_mask && !bad_resume_o));

    p_mask_subset_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        ((lane_mask_o & ~base_mask) == '0));
endmodule

// File: tb/vlane_pred_mask_tb_top.sv
module vlane_pred_mask_tb_top;
    localparam int CNT_W = 32;
    localparam int SZ_W  = 3;

    logic              clk = 1'b0;
    logic              rst_i;
    logic              load_i;
    logic [23:0]       load_pred_i;
    logic [3:0]        load_resume_i;
    logic              advance_i;
    logic [3:0]        cond_lo_i;
    logic [SZ_W-1:0]   elem_sz_i;
    logic [CNT_W-1:0]  loop_cnt_i;
    logic [15:0]       lane_mask_o;
    logic [23:0]       pred_o;
    logic [3:0]        resume_o;
    logic              bad_resume_o;

    always #2 clk = ~clk;

    vlane_pred_mask #(.CNT_W(CNT_W), .SZ_W(SZ_W)) dut_i (
        .clk_i         (clk),
        .rst_i         (rst_i),
        .load_i        (load_i),
        .load_pred_i   (load_pred_i),
        .load_resume_i (load_resume_i),
        .advance_i     (advance_i),
        .cond_lo_i     (cond_lo_i),
        .elem_sz_i     (elem_sz_i),
        .loop_cnt_i    (loop_cnt_i),
        .lane_mask_o   (lane_mask_o),
        .pred_o        (pred_o),
        .resume_o      (resume_o),
        .bad_resume_o  (bad_resume_o)
    );

    typedef struct {
        logic [15:0] mask;
        logic        bad;
        logic [23:0] pred;
        logic [3:0]  res;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          checks   = 0;
    int          failures = 0;
    logic [23:0] m_pred;
    logic [3:0]  m_res;
    bit          done     = 1'b0;

    function automatic logic [15:0] exp_mask(logic [23:0] p, logic [3:0] r,
                                             logic [3:0] c, int sz, longint cnt,
                                             output logic bad);
        logic [15:0] m;
        longint      len;
        m   = p[15:0];
        bad = 1'b0;
        if (p[19:16] == 4'd0) m[7:0]  = 8'hFF;
        if (p[23:20] == 4'd0) m[15:8] = 8'hFF;
        if (sz < 4 && cnt <= (16 >> sz)) begin
            len = cnt << sz;
            for (int i = 0; i < 16; i++) if (i >= len) m[i] = 1'b0;
        end
        if (c == 4'd0) begin
            case (r)
                4'd0:       ;
                4'd1:       m = m & 16'hFFF0;
                4'd2:       m = m & 16'hFF00;
                4'd4, 4'd5: m = m & 16'hF000;
                default:    bad = 1'b1;
            endcase
        end
        return m;
    endfunction

    task automatic step(input bit ld, input logic [23:0] lp, input logic [3:0] lr,
                        input bit adv, input logic [3:0] c, input int sz,
                        input longint cnt, input string tag);
        item_t it;
        logic  b;
        @(negedge clk);
        load_i        = ld;
        load_pred_i   = lp;
        load_resume_i = lr;
        advance_i     = adv;
        cond_lo_i     = c;
        elem_sz_i     = SZ_W'(sz);
        loop_cnt_i    = CNT_W'(cnt);
        it.mask = exp_mask(m_pred, m_res, c, sz, cnt, b);
        it.bad  = b;
        it.pred = m_pred;
        it.res  = m_res;
        it.tag  = tag;
        sb_q.push_back(it);
        if (ld) begin
            m_pred = lp;
            m_res  = lr;
        end else if (adv) begin
            if (c == 4'd0) m_res = (m_res == 4'd5) ? 4'd1 : 4'd0;
            if (m_pred[23:16] != 8'd0) begin
                if (m_pred[19:16] > 4'd8) m_pred[7:0]  = ~m_pred[7:0];
                if (m_pred[23:20] > 4'd8) m_pred[15:8] = ~m_pred[15:8];
                m_pred[19:16] = {m_pred[18:16], 1'b0};
                m_pred[23:20] = {m_pred[22:20], 1'b0};
            end
        end
    endtask

    task automatic idle(input logic [3:0] c, input int sz, input longint cnt, input string tag);
        step(1'b0, 24'd0, 4'd0, 1'b0, c, sz, cnt, tag);
    endtask

    task automatic ld(input logic [23:0] p, input logic [3:0] r, input string tag);
        step(1'b1, p, r, 1'b0, 4'd0, 4, 0, tag);
    endtask

    // monitor: compare one queued item per cycle, 1 ns after the driving edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (lane_mask_o !== it.mask || bad_resume_o !== it.bad ||
                    pred_o !== it.pred || resume_o !== it.res) begin
                    failures++;
                    $display("FAIL %s: mask=%h bad=%b pred=%h res=%h expected mask=%h bad=%b pred=%h res=%h",
                             it.tag, lane_mask_o, bad_resume_o, pred_o, resume_o,
                             it.mask, it.bad, it.pred, it.res);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_i = 1'b1; load_i = 1'b0; load_pred_i = '0; load_resume_i = '0;
        advance_i = 1'b0; cond_lo_i = '0; elem_sz_i = SZ_W'(4); loop_cnt_i = '0;
        m_pred = '0; m_res = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_i = 1'b0;

        idle(4'd0, 4, 0, "R1 reset state");

        // base mask from lane bits and step fields
        ld(24'h00_1234, 4'd0, "R10 load");
        idle(4'd0, 4, 0, "R2 both fields zero");
        ld(24'h08_1234, 4'd0, "R10 load");
        idle(4'd0, 4, 0, "R2 high half forced");
        ld(24'h40_1234, 4'd0, "R10 load");
        idle(4'd0, 4, 0, "R2 low half forced");

        // tail clip
        ld(24'h88_FFFF, 4'd0, "R10 load");
        idle(4'd0, 0, 5,  "R3 bytes count 5");
        idle(4'd0, 1, 3,  "R3 halves count 3");
        idle(4'd0, 2, 4,  "R3 words count at limit");
        idle(4'd0, 2, 5,  "R3 words count over limit");
        idle(4'd0, 2, 0,  "R3 count zero");
        idle(4'd0, 3, 1,  "R3 doublewords count 1");
        idle(4'd0, 4, 1,  "R3 size code disables");

        // beat gating
        ld(24'h88_FFFF, 4'd1, "R10 load");
        idle(4'd0, 4, 0, "R4 beat0");
        ld(24'h88_FFFF, 4'd2, "R10 load");
        idle(4'd0, 4, 0, "R4 beat01");
        idle(4'd3, 4, 0, "R6 cond nonzero no gating");
        ld(24'h88_FFFF, 4'd4, "R10 load");
        idle(4'd0, 4, 0, "R4 beat012");
        ld(24'h88_FFFF, 4'd5, "R10 load");
        idle(4'd0, 2, 2, "R4 beat012 next with tail");
        ld(24'h88_FFFF, 4'd3, "R10 load");
        idle(4'd0, 4, 0, "R5 unsupported code 3");
        idle(4'd6, 4, 0, "R6 unsupported code masked by cond");
        ld(24'h88_0F0F, 4'd7, "R10 load");
        idle(4'd0, 4, 0, "R5 unsupported code 7");

        // resume transitions
        ld(24'h00_0000, 4'd5, "R10 load");
        step(1'b0, 24'd0, 4'd0, 1'b1, 4'd0, 4, 0, "R7 rearm advance");
        idle(4'd0, 4, 0, "R7 after rearm");
        step(1'b0, 24'd0, 4'd0, 1'b1, 4'd0, 4, 0, "R7 clear advance");
        idle(4'd0, 4, 0, "R7 after clear");
        ld(24'h00_0000, 4'd2, "R10 load");
        step(1'b0, 24'd0, 4'd0, 1'b1, 4'd9, 4, 0, "R6 advance cond nonzero");
        idle(4'd0, 4, 0, "R6 resume kept");

        // predicate stepping
        ld(24'h8C_00FF, 4'd0, "R10 load");
        step(1'b0, 24'd0, 4'd0, 1'b1, 4'd0, 4, 0, "R9 advance invert low");
        idle(4'd0, 4, 0, "R9 after first step");
        step(1'b0, 24'd0, 4'd0, 1'b1, 4'd0, 4, 0, "R9 advance no invert");
        idle(4'd0, 4, 0, "R9 after second step");
        step(1'b0, 24'd0, 4'd0, 1'b1, 4'd0, 4, 0, "R8 advance fields zero");
        idle(4'd0, 4, 0, "R8 predicate kept");
        ld(24'hF6_A55A, 4'd0, "R10 load");
        step(1'b0, 24'd0, 4'd0, 1'b1, 4'd0, 4, 0, "R9 advance invert high");
        idle(4'd0, 4, 0, "R9 high byte inverted");

        // load priority and hold
        step(1'b1, 24'h11_3C3C, 4'd1, 1'b1, 4'd0, 4, 0, "R10 load with advance");
        idle(4'd0, 4, 0, "R10 load won");
        idle(4'd0, 4, 0, "R11 hold one");
        idle(4'd2, 1, 2, "R11 hold two");
        idle(4'd0, 4, 0, "R11 hold three");

        @(negedge clk);
        @(negedge clk);
        #2;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule